// File: doc/BRIEF.md
# Punctured soft-symbol depuncturer

This block sits between the symbol framing logic and a rate-1/2 convolutional decoder core. It receives a stream of 3-bit soft decisions, one per cycle when a valid strobe is high, and rebuilds the full X/Y symbol pairs that the mother code produced. Positions that the transmitter removed are refilled with a neutral soft value, and a per-half erasure flag marks them so that the decoder can give them zero branch-metric weight.

The rate code and a column offset come from the synchronizer. The rate code selects one of five puncture patterns. The offset selects the pattern column at which a received stream starts. Whenever either value changes, the pattern restarts at the commanded column with the next valid symbol. The input buffer and the clock generation sit outside the block. The block raises a stall request in each cycle after one in which it needed a symbol and none arrived. All outputs are registered.

Top module: `depuncturer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` and `stall_req` are both 0.
- R2: Rate code 0 (rate 1/2, pattern period 1, X and Y both sent) pairs symbols in arrival order. The first symbol becomes X and the second becomes Y, with no erasure flags. The pair appears one cycle after the second symbol.
- R3: Rate code 1 (2/3) uses the column sequence {X+Y, X only} with period 2.
- R4: Rate code 2 (3/4) uses the column sequence {X+Y, X only, Y only} with period 3.
- R5: Rate code 3 (5/6) uses the column sequence {X+Y, X only, Y only, X only, Y only} with period 5.
- R6: Rate code 4 (7/8) uses the column sequence {X+Y, X, X, X, Y, X, Y} with period 7.
- R7: A deleted half is output as the value 4 (binary 100) with its erasure flag set to 1. A transmitted half has its flag set to 0. Both flags are never set in the same pair.
- R8: In a column that carries both halves, the earlier received symbol is X and the later one is Y. The pair is emitted one cycle after the later symbol arrives.
- R9: A change of `rate_sel` or `phase_sel`, made on any cycle, makes the next valid symbol start the commanded column. A half-collected column is discarded.
- R10: The start column is `phase_sel` modulo the pattern period of the selected rate.
- R11: No pair is emitted in the cycle after an input cycle that has no valid symbol. Gaps in the input do not change the pattern position.
- R12: `stall_req` is 1 exactly in the cycle after a cycle in which `in_valid` was 0.
- R13: Rate codes 5 to 7 behave the same as rate code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received soft symbol is present |
| in_sym | input | 3 | Received soft symbol |
| rate_sel | input | 3 | Puncture rate code (0 to 4; 5 to 7 act as 0) |
| phase_sel | input | 3 | Pattern column at which the stream starts |
| out_valid | output | 1 | A rebuilt X/Y pair is present |
| out_x | output | 3 | X soft value |
| out_x_era | output | 1 | X was deleted (erasure) |
| out_y | output | 3 | Y soft value |
| out_y_era | output | 1 | Y was deleted (erasure) |
| stall_req | output | 1 | The previous cycle lacked a needed symbol |

## Verification
The bench drives every rate with several start offsets. This includes offsets at or above the pattern period, where a design without the modulo step would index beyond the map and emit wrong erasure positions. A configuration change is made while a two-symbol column is half collected, and another is made during an idle gap. A design that keeps the held symbol, or that misses a change made without a valid strobe, would shift every later pair. Gaps are placed inside two-symbol columns to catch X/Y swaps and pattern slips, and the stall output is compared against the bench's own record of the input strobe in every cycle.

// File: rtl/depunct_pkg.sv
package depunct_pkg;

  localparam int RATE_W   = 3;
  localparam int MAX_COLS = 7;
  localparam int COL_W    = $clog2(MAX_COLS);

  // Column count of the puncture pattern for a rate code
  function automatic logic [COL_W:0] pattern_period(input logic [RATE_W-1:0] rate);
    case (rate)
      3'd1:    return (COL_W+1)'(2);
      3'd2:    return (COL_W+1)'(3);
      3'd3:    return (COL_W+1)'(5);
      3'd4:    return (COL_W+1)'(7);
      default: return (COL_W+1)'(1);
    endcase
  endfunction

  // Bit c set: the X half of column c is transmitted
  function automatic logic [MAX_COLS-1:0] x_sent_mask(input logic [RATE_W-1:0] rate);
    case (rate)
      3'd1:    return 7'b0000011;
      3'd2:    return 7'b0000011;
      3'd3:    return 7'b0001011;
      3'd4:    return 7'b0101111;
      default: return 7'b0000001;
    endcase
  endfunction

  // Bit c set: the Y half of column c is transmitted
  function automatic logic [MAX_COLS-1:0] y_sent_mask(input logic [RATE_W-1:0] rate);
    case (rate)
      3'd1:    return 7'b0000001;
      3'd2:    return 7'b0000101;
      3'd3:    return 7'b0010101;
      3'd4:    return 7'b1010001;
      default: return 7'b0000001;
    endcase
  endfunction

endpackage

// File: rtl/depunct_map.sv
module depunct_map
  import depunct_pkg::*;
(
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [COL_W-1:0]  col,
  output logic              x_tx,
  output logic              y_tx
);
  localparam int PAD = 1 << COL_W;

  logic [MAX_COLS-1:0] xm, ym;
  logic [PAD-1:0]      xpad, ypad;

  assign xm = x_sent_mask(rate_sel);
  assign ym = y_sent_mask(rate_sel);

  for (genvar c = 0; c < PAD; c++) begin : g_pad
    if (c < MAX_COLS) begin : g_live
      assign xpad[c] = xm[c];
      assign ypad[c] = ym[c];
    end else begin : g_dead
      assign xpad[c] = 1'b1;
      assign ypad[c] = 1'b1;
    end
  end

  assign x_tx = xpad[col];
  assign y_tx = ypad[col];
endmodule

// File: rtl/depunct_phase.sv
module depunct_phase
  import depunct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [COL_W-1:0]  phase_sel,
  input  logic              col_done,
  output logic [COL_W-1:0]  cur_col,
  output logic              restart
);
  logic [RATE_W-1:0] rate_q;
  logic [COL_W-1:0]  phase_q;
  logic [COL_W-1:0]  col_q;
  logic              pending_q;
  logic [COL_W:0]    period;
  logic [COL_W:0]    start_wide;
  logic [COL_W-1:0]  start_col;
  logic [COL_W-1:0]  nxt_col;

  assign period     = pattern_period(rate_sel);
  assign start_wide = {1'b0, phase_sel} % period;
  assign start_col  = start_wide[COL_W-1:0];
  assign restart    = pending_q | (rate_sel != rate_q) | (phase_sel != phase_q);
  assign cur_col    = restart ? start_col : col_q;
  assign nxt_col    = ({1'b0, cur_col} == period - 1'b1) ? '0 : cur_col + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q    <= '0;
      phase_q   <= '0;
      col_q     <= '0;
      pending_q <= 1'b1;
    end else begin
      rate_q  <= rate_sel;
      phase_q <= phase_sel;
      if (in_valid) begin
        pending_q <= 1'b0;
        col_q     <= col_done ? nxt_col : cur_col;
      end else if (restart) begin
        pending_q <= 1'b1;
      end
    end
  end

  // R10: with no restart pending, the stored column lies inside the pattern
  assert_col_in_period_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !restart) |-> ({1'b0, col_q} < period));

  // R9: a configuration change seen without a valid symbol is remembered
  assert_change_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && (rate_sel != rate_q)) |=> restart);
endmodule

// File: rtl/depunct_assemble.sv
module depunct_assemble #(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             restart,
  input  logic             x_tx,
  input  logic             y_tx,
  output logic             col_done,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_x,
  output logic             out_x_era,
  output logic [SYM_W-1:0] out_y,
  output logic             out_y_era,
  output logic             stall_req
);
  localparam logic [SYM_W-1:0] NEUTRAL = SYM_W'(1) << (SYM_W - 1);

  logic             held_q;
  logic [SYM_W-1:0] hold_sym_q;
  logic             held_eff;
  logic             capture;
  logic             emit;
  logic [SYM_W-1:0] nx, ny;
  logic             nxe, nye;

  assign held_eff = held_q & ~restart;

  always_comb begin
    capture  = 1'b0;
    emit     = 1'b0;
    col_done = 1'b0;
    nx       = NEUTRAL;
    ny       = NEUTRAL;
    nxe      = 1'b0;
    nye      = 1'b0;
    if (in_valid) begin
      if (held_eff) begin
        emit = 1'b1; col_done = 1'b1;
        nx = hold_sym_q; ny = in_sym;
      end else if (x_tx && y_tx) begin
        capture = 1'b1;
      end else if (x_tx) begin
        emit = 1'b1; col_done = 1'b1;
        nx = in_sym; nye = 1'b1;
      end else begin
        emit = 1'b1; col_done = 1'b1;
        ny = in_sym; nxe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= 1'b0;
      hold_sym_q <= '0;
      out_valid  <= 1'b0;
      out_x      <= '0;
      out_y      <= '0;
      out_x_era  <= 1'b0;
      out_y_era  <= 1'b0;
      stall_req  <= 1'b0;
    end else begin
      out_valid <= emit;
      stall_req <= ~in_valid;
      if (in_valid) held_q <= capture;
      if (capture) hold_sym_q <= in_sym;
      if (emit) begin
        out_x     <= nx;
        out_y     <= ny;
        out_x_era <= nxe;
        out_y_era <= nye;
      end
    end
  end

  // R7: erased halves carry the neutral value and never both at once
  assert_x_era_neutral_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_x_era) |-> (out_x == NEUTRAL));
  assert_y_era_neutral_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_y_era) |-> (out_y == NEUTRAL));
  assert_not_both_era_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_x_era && out_y_era));
  // R8: a symbol is only held inside a column that carries both halves
  assert_hold_full_col_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && held_q && !restart) |-> (x_tx && y_tx));
  // R11: no pair follows an empty input cycle
  assert_gap_no_out_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R12: stall follows an empty input cycle and only that
  assert_stall_follows_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> stall_req);
  assert_stall_clear_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !stall_req);
endmodule

// File: rtl/depuncturer.sv
module depuncturer
  import depunct_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SYM_W-1:0]  in_sym,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [COL_W-1:0]  phase_sel,
  output logic              out_valid,
  output logic [SYM_W-1:0]  out_x,
  output logic              out_x_era,
  output logic [SYM_W-1:0]  out_y,
  output logic              out_y_era,
  output logic              stall_req
);
  logic [COL_W-1:0] cur_col;
  logic             restart;
  logic             col_done;
  logic             x_tx, y_tx;

  depunct_phase u_phase (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .rate_sel(rate_sel), .phase_sel(phase_sel),
    .col_done(col_done), .cur_col(cur_col), .restart(restart)
  );

  depunct_map u_map (
    .rate_sel(rate_sel), .col(cur_col), .x_tx(x_tx), .y_tx(y_tx)
  );

  depunct_assemble #(.SYM_W(SYM_W)) u_asm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .restart(restart), .x_tx(x_tx), .y_tx(y_tx), .col_done(col_done),
    .out_valid(out_valid), .out_x(out_x), .out_x_era(out_x_era),
    .out_y(out_y), .out_y_era(out_y_era), .stall_req(stall_req)
  );

  // R1: quiet outputs in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !stall_req));
endmodule

// File: tb/test_depuncturer.sv
module test_depuncturer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] in_sym = '0;
  logic [2:0] rate_sel = '0;
  logic [2:0] phase_sel = '0;
  logic       out_valid, out_x_era, out_y_era, stall_req;
  logic [2:0] out_x, out_y;

  always #10 clk = ~clk; // 50 MHz

  depuncturer i_depuncturer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .rate_sel(rate_sel), .phase_sel(phase_sel), .out_valid(out_valid),
    .out_x(out_x), .out_x_era(out_x_era), .out_y(out_y),
    .out_y_era(out_y_era), .stall_req(stall_req)
  );

  typedef struct packed {
    logic [2:0] x;
    logic       xe;
    logic [2:0] y;
    logic       ye;
  } pair_t;

  pair_t q_exp[$];
  string q_tag[$];
  int    total = 0;
  int    bad = 0;
  string cur_tag = "R2";
  bit    mon_on = 1'b0;
  logic  iv_prev = 1'b1;

  // bench-side pattern model, from the requirement text
  logic [2:0] cfg_rate = 0, cfg_phase = 0, last_rate = 0, last_phase = 0;
  bit         m_pending = 1'b1;
  int         m_col = 0;
  bit         m_held = 1'b0;
  logic [2:0] m_hold = 0;
  int         sym_cnt = 0;

  function automatic int per_of(input logic [2:0] r);
    case (r) 3'd1: return 2; 3'd2: return 3; 3'd3: return 5; 3'd4: return 7; default: return 1; endcase
  endfunction
  // column kinds: 3 = both, 1 = X only, 2 = Y only
  function automatic int kind_of(input logic [2:0] r, input int c);
    case (r)
      3'd1: return (c == 0) ? 3 : 1;
      3'd2: return (c == 0) ? 3 : (c == 1) ? 1 : 2;
      3'd3: begin int k[5] = '{3, 1, 2, 1, 2}; return k[c]; end
      3'd4: begin int k[7] = '{3, 1, 1, 1, 2, 1, 2}; return k[c]; end
      default: return 3;
    endcase
  endfunction

  task automatic expect_pair(input logic [2:0] x, input logic xe, input logic [2:0] y, input logic ye);
    pair_t p;
    p.x = x; p.xe = xe; p.y = y; p.ye = ye;
    q_exp.push_back(p);
    q_tag.push_back(cur_tag);
  endtask

  task automatic model(input logic [2:0] s);
    int k;
    if (m_pending) begin
      m_col = int'(cfg_phase) % per_of(cfg_rate); // R10, R9
      m_held = 1'b0;
      m_pending = 1'b0;
    end
    k = kind_of(cfg_rate, m_col);
    if (m_held) begin
      expect_pair(m_hold, 1'b0, s, 1'b0); // R8: earlier is X
      m_held = 1'b0;
      m_col = (m_col + 1) % per_of(cfg_rate);
    end else if (k == 3) begin
      m_hold = s; m_held = 1'b1;
    end else if (k == 1) begin
      expect_pair(s, 1'b0, 3'd4, 1'b1); // R7
      m_col = (m_col + 1) % per_of(cfg_rate);
    end else begin
      expect_pair(3'd4, 1'b1, s, 1'b0); // R7
      m_col = (m_col + 1) % per_of(cfg_rate);
    end
  endtask

  task automatic drive(input bit v);
    logic [2:0] s;
    @(negedge clk);
    s = 3'((sym_cnt * 5 + 3) % 8);
    sym_cnt++;
    rate_sel = cfg_rate; phase_sel = cfg_phase;
    in_valid = v; in_sym = v ? s : 3'd0;
    if (cfg_rate != last_rate || cfg_phase != last_phase) m_pending = 1'b1;
    last_rate = cfg_rate; last_phase = cfg_phase;
    if (v) model(s);
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  always @(posedge clk) iv_prev <= rst ? 1'b1 : in_valid;

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      total++;
      if (stall_req !== !iv_prev) begin // R12
        bad++;
        $display("FAIL R12 stall_req actual=%b expected=%b", stall_req, !iv_prev);
      end
      if (out_valid) begin
        total++;
        if (q_exp.size() == 0) begin // R11
          bad++;
          $display("FAIL R11 unexpected pair actual=%h/%h expected=none", out_x, out_y);
        end else begin
          pair_t e, a;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          a.x = out_x; a.xe = out_x_era; a.y = out_y; a.ye = out_y_era;
          // R7 erasure value/flags and R8 X/Y order are covered by this compare
          if (a !== e) begin
            bad++;
            $display("FAIL %s pair actual x=%0d xe=%b y=%0d ye=%b expected x=%0d xe=%b y=%0d ye=%b",
                     t, a.x, a.xe, a.y, a.ye, e.x, e.xe, e.y, e.ye);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || stall_req !== 1'b0) begin // R1
      bad++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", out_valid, stall_req);
    end
    rst = 1'b0;
    mon_on = 1'b1;

    cur_tag = "R2";  cfg_rate = 0; cfg_phase = 0; push_n(6);
    cur_tag = "R12"; idle_n(2);
    cur_tag = "R13"; cfg_rate = 5; push_n(4); cfg_rate = 7; push_n(4);
    cur_tag = "R3";  cfg_rate = 1; cfg_phase = 0; push_n(9);
    cur_tag = "R11";
    for (int i = 0; i < 6; i++) begin drive(1'b1); idle_n(1 + (i % 2)); end
    cur_tag = "R4";  cfg_rate = 2; cfg_phase = 1; push_n(9);
    cur_tag = "R5";  cfg_rate = 3; cfg_phase = 0; push_n(12);
    cur_tag = "R10"; cfg_phase = 3; push_n(10);
    cur_tag = "R6";  cfg_rate = 4; cfg_phase = 0; push_n(16);
    cur_tag = "R10"; cfg_phase = 7; push_n(9); cfg_phase = 6; push_n(9);
    cfg_rate = 1; cfg_phase = 5; push_n(6);
    cur_tag = "R9";  cfg_rate = 4; cfg_phase = 0; push_n(1);
    cfg_phase = 2; push_n(8);
    cfg_phase = 0; push_n(1); cfg_rate = 2; idle_n(3); push_n(7);
    cur_tag = "R11"; idle_n(4);

    total++;
    if (q_exp.size() != 0) begin
      bad++;
      $display("FAIL R11 missing pairs actual=%0d left expected=0", q_exp.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule